// File: doc/BRIEF.md
# Tagged Receive Interrupt Coalescer

This block runs next to a receive DMA engine. Each time the engine finishes writing a received message into host memory, it sends the block a strobe. The block counts these messages. It also records whether the transmit side has finished with a buffer page. When enough messages have gathered, or when something has waited too long, the block emits a 32-bit status word for the DMA engine to place at the head of the receive area, and it raises the channel's interrupt line.

Every report carries a rolling 4-bit tag. After a report the block stays silent until the host writes back the tag it expects next, which is the reported tag plus one, wrapping from 15 to 0. Because of this, software sharing one interrupt line among several channels can tell which channel raised it, by comparing the tag found in memory with the tag it expects. Events that arrive while the block waits for the acknowledge are kept and go into the following report.

A 100 µs tick from outside gives the time base. An enable input gates interrupt generation. A reset-mode input stops the engine and discards its state.

Top module: `rx_irq_coalescer`

## Requirements
- R1: The count limit is `limits_i[7:0]`. When the pending message count is nonzero and at least the count limit, a status write (`stat_we_o`) occurs in the cycle after the message that reached the limit was sampled. No write occurs below the limit.
- R2: The time limit is `limits_i[15:8]`, counted in ticks of `tick_i`. The timer starts from zero when an event becomes pending while the block is not waiting, or at an accepted acknowledge if events are already pending. A report occurs once that many ticks have been seen. A time limit of 0 reports as soon as anything is pending.
- R3: The status word carries the tag in bits 3:0, the message count in bits 10:4 and the page-link flag in bit 16. All other bits are zero.
- R4: After a report, `irq_o` stays high and no further report is made until an acknowledge arrives whose value equals the report tag plus 1 (mod 16). That value clears `irq_o` and becomes the next report's tag, so successive tags wrap from 15 to 0.
- R5: An acknowledge with any other value while waiting is ignored: `irq_o` stays high and no report is made.
- R6: Messages and ticks that arrive while waiting are not lost. The accumulated count is reported after the correct acknowledge, at once if the count limit is already met.
- R7: A message sampled in the same cycle as a report is left out of that report and counted toward the next one.
- R8: The pending message count saturates at 127.
- R9: While `irq_en_i` is low, no status write occurs and `irq_o` is low, but events keep accumulating. Raising `irq_en_i` lets a due report go out.
- R10: While `dma_rst_i` is high, pending events are discarded, the timer stops, the wait state clears, the tag returns to 0, `irq_o` is low, and acknowledges and events are ignored.
- R11: A `page_done_i` strobe sets the link flag. A link alone counts as a pending event on the time path and is reported with count 0.
- R12: An acknowledge written while the block is not waiting loads the tag used for the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_wr_i | input | 1 | One received message has been written to host memory |
| page_done_i | input | 1 | Transmit page consumed (link event) |
| limits_i | input | 16 | [7:0] count limit, [15:8] time limit in ticks |
| ack_we_i | input | 1 | Host acknowledge write strobe |
| ack_tag_i | input | 4 | Tag value written by the host |
| irq_en_i | input | 1 | Interrupt enable |
| dma_rst_i | input | 1 | Reset mode: engine stopped and cleared |
| tick_i | input | 1 | 100 µs time-base pulse |
| stat_we_o | output | 1 | One-cycle strobe: status word valid |
| stat_word_o | output | 32 | Status word for the head of the receive area |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can land in the same cycle: the issue of a report, and the arrival of a new message. The bench provokes this by sending one more message than the count limit, back to back. The extra message is then sampled exactly in the cycle the report fires. The check passes only if the first report shows exactly the limit and the next report, after the acknowledge, needs one message fewer to reach the same limit. That outcome proves the extra message was neither dropped nor merged into the first report.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int TAG_W   = 4;
    localparam int CNT_W   = 7;
    localparam int LIM_W   = 8;
    localparam int WORD_W  = 32;
    localparam int CNT_LSB = 4;
    localparam int LNK_BIT = 16;
endpackage

// File: rtl/coal_accum.sv
module coal_accum #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             flush,
    input  logic             msg,
    input  logic             lnk_ev,
    output logic [CNT_W-1:0] cnt,
    output logic             lnk
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q, base;
    logic             lnk_d, lnk_q;

    always_comb begin
        base  = flush ? '0 : cnt_q;
        cnt_d = base;
        if (msg && (base != CNT_MAX)) cnt_d = base + 1'b1;
        lnk_d = (flush ? 1'b0 : lnk_q) | lnk_ev;
        if (clr) begin
            cnt_d = '0;
            lnk_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lnk_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            lnk_q <= lnk_d;
        end
    end

    assign cnt = cnt_q;
    assign lnk = lnk_q;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !flush && !clr) |=> (cnt_q == CNT_MAX)); // R8
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    output logic [LIM_W-1:0] ticks
);
    localparam logic [LIM_W-1:0] T_MAX = '1;

    logic [LIM_W-1:0] t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!run)                     t_d = '0;
        else if (tick && t_q != T_MAX) t_d = t_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ticks = t_q;

    AST_TIMER_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (t_q == '0)); // R2
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer #(
    parameter int TAG_W  = coal_pkg::TAG_W,
    parameter int CNT_W  = coal_pkg::CNT_W,
    parameter int LIM_W  = coal_pkg::LIM_W,
    parameter int WORD_W = coal_pkg::WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_wr_i,
    input  logic               page_done_i,
    input  logic [2*LIM_W-1:0] limits_i,
    input  logic               ack_we_i,
    input  logic [TAG_W-1:0]   ack_tag_i,
    input  logic               irq_en_i,
    input  logic               dma_rst_i,
    input  logic               tick_i,
    output logic               stat_we_o,
    output logic [WORD_W-1:0]  stat_word_o,
    output logic               irq_o
);
    localparam int CNT_LSB = coal_pkg::CNT_LSB;
    localparam int LNK_BIT = coal_pkg::LNK_BIT;

    typedef struct packed {
        logic              waiting;
        logic [TAG_W-1:0]  tag;
        logic              we;
        logic [WORD_W-1:0] word;
    } rpt_t;

    rpt_t st_d, st_q;

    logic [CNT_W-1:0] cnt;
    logic             lnk;
    logic [LIM_W-1:0] ticks;
    logic [LIM_W-1:0] cnt_lim, tim_lim;
    logic [TAG_W-1:0] next_tag;
    logic             pending, cnt_hit, tim_hit, fire, run;

    assign cnt_lim  = limits_i[LIM_W-1:0];
    assign tim_lim  = limits_i[2*LIM_W-1:LIM_W];
    assign next_tag = TAG_W'(st_q.tag + 1'b1);
    assign pending  = (cnt != '0) || lnk;
    assign cnt_hit  = (cnt != '0) && (LIM_W'(cnt) >= cnt_lim);
    assign tim_hit  = pending && (ticks >= tim_lim);
    assign fire     = irq_en_i && !dma_rst_i && !st_q.waiting && (cnt_hit || tim_hit);
    assign run      = pending && !st_q.waiting && !dma_rst_i;

    coal_accum #(.CNT_W(CNT_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (dma_rst_i),
        .flush  (fire),
        .msg    (msg_wr_i),
        .lnk_ev (page_done_i),
        .cnt    (cnt),
        .lnk    (lnk)
    );

    coal_timer #(.LIM_W(LIM_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick_i),
        .ticks (ticks)
    );

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (fire) begin
            st_d.we                     = 1'b1;
            st_d.waiting                = 1'b1;
            st_d.word                   = '0;
            st_d.word[TAG_W-1:0]        = st_q.tag;
            st_d.word[CNT_LSB +: CNT_W] = cnt;
            st_d.word[LNK_BIT]          = lnk;
        end else if (ack_we_i && !dma_rst_i) begin
            if (!st_q.waiting) begin
                st_d.tag = ack_tag_i;
            end else if (ack_tag_i == next_tag) begin
                st_d.waiting = 1'b0;
                st_d.tag     = ack_tag_i;
            end
        end
        if (dma_rst_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_we_o   = st_q.we;
    assign stat_word_o = st_q.word;
    assign irq_o       = st_q.waiting && irq_en_i;

    AST_ACK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.waiting && ack_we_i && !dma_rst_i && ack_tag_i == next_tag)
        |=> (!st_q.waiting && st_q.tag == $past(ack_tag_i))); // R4
    AST_BAD_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.waiting && !dma_rst_i && !(ack_we_i && ack_tag_i == next_tag))
        |=> (st_q.waiting && !stat_we_o)); // R5
    AST_REPORT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we_o |-> (st_q.waiting && stat_word_o[TAG_W-1:0] == st_q.tag)); // R3
    AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |=> !stat_we_o); // R9
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rst_i |=> (!stat_we_o && !irq_o && cnt == '0 && !lnk && ticks == '0)); // R10
endmodule

// File: tb/sim_rx_irq_coalescer.sv
`timescale 1ns/1ps
module sim_rx_irq_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_wr_i = 1'b0, page_done_i = 1'b0, ack_we_i = 1'b0;
    logic        irq_en_i = 1'b1, dma_rst_i = 1'b0, tick_i = 1'b0;
    logic [15:0] limits_i = 16'h0A10;
    logic [3:0]  ack_tag_i = 4'd0;
    logic        stat_we_o, irq_o;
    logic [31:0] stat_word_o;

    int n_chk = 0, n_fail = 0, n_rep = 0;
    logic [31:0] last_word = '0;
    int exp_tag = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_irq_coalescer u0 (
        .clk(clk), .rst_n(rst_n), .msg_wr_i(msg_wr_i), .page_done_i(page_done_i),
        .limits_i(limits_i), .ack_we_i(ack_we_i), .ack_tag_i(ack_tag_i),
        .irq_en_i(irq_en_i), .dma_rst_i(dma_rst_i), .tick_i(tick_i),
        .stat_we_o(stat_we_o), .stat_word_o(stat_word_o), .irq_o(irq_o)
    );

    always @(negedge clk) if (stat_we_o) begin
        n_rep     = n_rep + 1;
        last_word = stat_word_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int c, input bit l, input int t);
        return (32'(l) << 16) | (32'(c) << 4) | 32'(t & 15);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic send(input int n);
        repeat (n) begin @(negedge clk); msg_wr_i = 1'b1; end
        @(negedge clk); msg_wr_i = 1'b0;
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
        #1;
    endtask

    task automatic ack(input int t);
        @(negedge clk); ack_we_i = 1'b1; ack_tag_i = 4'(t);
        @(negedge clk); ack_we_i = 1'b0;
        #1;
    endtask

    task automatic expect_rep(input string req, input int base, input int c, input bit l);
        chk(req, 32'(n_rep - base), 32'd1);
        chk(req, last_word, mk_word(c, l, exp_tag));
    endtask

    task automatic ack_ok();
        ack((exp_tag + 1) & 15);
        exp_tag = (exp_tag + 1) & 15;
        chk("R4 irq cleared by ack", 32'(irq_o), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        chk("R4 reset irq low", 32'(irq_o), 32'd0);
        chk("R1 reset no write", 32'(n_rep), 32'd0);

        // R1 default limits 16 msgs / 10 ticks
        base = n_rep;
        send(15); idle(3);
        chk("R1 below default limit", 32'(n_rep - base), 32'd0);
        send(1); idle(1);
        expect_rep("R1 default count 16", base, 16, 1'b0);
        ack_ok();

        // R1 R3 R4 count sweep; tag wraps
        for (int k = 1; k <= 20; k++) begin
            limits_i = {8'd200, 8'(k)};
            base = n_rep;
            if (k > 1) begin
                send(k - 1); idle(3);
                chk("R1 no report below limit", 32'(n_rep - base), 32'd0);
            end
            send(1); idle(1);
            expect_rep("R1 R3 count-limit report", base, k, 1'b0);
            chk("R4 irq high after report", 32'(irq_o), 32'd1);
            ack_ok();
        end

        // R2 time sweep
        for (int tl = 0; tl <= 5; tl++) begin
            limits_i = {8'(tl), 8'd200};
            base = n_rep;
            send(1);
            if (tl > 0) begin
                tick(tl - 1); idle(3);
                chk("R2 no report before time limit", 32'(n_rep - base), 32'd0);
                tick(1);
            end
            idle(2);
            expect_rep("R2 time-limit report", base, 1, 1'b0);
            ack_ok();
        end

        // R11 link alone
        limits_i = {8'd2, 8'd200};
        base = n_rep;
        @(negedge clk); page_done_i = 1'b1;
        @(negedge clk); page_done_i = 1'b0;
        tick(2); idle(2);
        expect_rep("R11 link-only report", base, 0, 1'b1);
        ack_ok();

        // R7 message in the report cycle
        limits_i = {8'd200, 8'd3};
        base = n_rep;
        send(4); idle(2);
        expect_rep("R7 report excludes same-cycle msg", base, 3, 1'b0);
        ack_ok();
        base = n_rep;
        idle(3);
        chk("R7 carried msg alone below limit", 32'(n_rep - base), 32'd0);
        send(2); idle(2);
        expect_rep("R7 carried msg counted next", base, 3, 1'b0);
        ack_ok();

        // R5 R6 wrong acks, accumulation during wait
        limits_i = {8'd200, 8'd2};
        base = n_rep;
        send(2); idle(2);
        expect_rep("R5 setup report", base, 2, 1'b0);
        base = n_rep;
        ack(exp_tag);
        ack((exp_tag + 2) & 15);
        send(5); tick(3); idle(3);
        chk("R5 wrong ack no report", 32'(n_rep - base), 32'd0);
        chk("R5 wrong ack irq held", 32'(irq_o), 32'd1);
        ack_ok();
        idle(2);
        expect_rep("R6 accumulated report", base, 5, 1'b0);
        ack_ok();

        // R8 saturation
        limits_i = {8'd1, 8'd200};
        base = n_rep;
        send(130); idle(3);
        chk("R8 no report at count 127 under limit 200", 32'(n_rep - base), 32'd0);
        tick(1); idle(2);
        expect_rep("R8 count saturates at 127", base, 127, 1'b0);
        ack_ok();

        // R9 enable
        limits_i = {8'd200, 8'd2};
        irq_en_i = 1'b0;
        base = n_rep;
        send(4); idle(3);
        chk("R9 disabled no report", 32'(n_rep - base), 32'd0);
        chk("R9 disabled irq low", 32'(irq_o), 32'd0);
        @(negedge clk); irq_en_i = 1'b1;
        idle(2);
        expect_rep("R9 enable releases report", base, 4, 1'b0);
        @(negedge clk); irq_en_i = 1'b0; #1;
        chk("R9 irq masked by enable", 32'(irq_o), 32'd0);
        @(negedge clk); irq_en_i = 1'b1; #1;
        ack_ok();

        // R10 reset mode
        base = n_rep;
        send(2); idle(2);
        expect_rep("R10 setup report", base, 2, 1'b0);
        @(negedge clk); dma_rst_i = 1'b1;
        idle(2);
        chk("R10 irq low in reset mode", 32'(irq_o), 32'd0);
        send(3);
        ack((exp_tag + 1) & 15);
        @(negedge clk); dma_rst_i = 1'b0;
        limits_i = {8'd1, 8'd2};
        base = n_rep;
        tick(5); idle(3);
        chk("R10 pending discarded", 32'(n_rep - base), 32'd0);
        exp_tag = 0;
        send(2); idle(2);
        expect_rep("R10 tag back to 0", base, 2, 1'b0);
        ack_ok();

        // R12 arming ack while idle
        ack(9);
        exp_tag = 9;
        base = n_rep;
        send(2); idle(2);
        expect_rep("R12 armed tag used", base, 2, 1'b0);
        ack_ok();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule